// File: doc/BRIEF.md
# Angle Latch Output Port

This block connects the reversible 16-bit angle counter of a tracking angle converter to a shared parallel bus. The tracking loop sends single-cycle up or down step pulses. The block keeps the counter and raises a busy strobe for every step, and it moves the counter into an output latch during a separate load interval. That interval starts when busy falls and is as long as the busy pulse. A host reads the latch through two byte lanes. Each lane has its own active-low enable and goes to high impedance when that enable is released.

A host can freeze the latch with an active-low inhibit. While the latch is frozen the counter keeps tracking. When inhibit is released, the block runs one catch-up load so that the latch matches the counter again. A timed ripple pulse marks every full-scale wrap, in either direction. A fault flag is high while tracking is healthy. It drops when the front end reports loss of signal, or when the backlog of unprocessed steps shows that the loop has fallen behind.

The step inputs have no back-pressure. Every pulse is accepted in the cycle it arrives and is held in a signed backlog, so the source never waits. All pulse widths and delays are parameters in clock cycles.

Top module: `angle_out_if`

## Requirements
- R1: After reset the latch and the counter are zero, busy and ripple are low, fault_ok is high, and both byte lanes are at high impedance until their enables have been low for EN_DLY cycles.
- R2: Each processed step moves the counter by one: up adds one and down subtracts one, modulo 2^16, in natural binary. The counter changes in the same cycle that busy rises, and busy then stays high for exactly BUSY_W cycles.
- R3: The latch does not change while busy is high. After busy falls there is a load interval of BUSY_W cycles, and the latch takes the counter value on the clock edge that ends that interval.
- R4: While inhibit_n is low the latch holds its value, but steps are still processed, busy pulses are still produced and the counter still moves.
- R5: A rising edge of inhibit_n with no step pending starts one load interval of BUSY_W cycles without a busy pulse, and after it the latch equals the counter.
- R6: A step that arrives while a busy or load interval is running is queued and processed afterwards, so no step is lost. An up and a down pulse in the same cycle cancel, and produce no busy pulse.
- R7: angle_bus[15:8] carries latch bits 15..8 (bit 15 is the MSB) and angle_bus[7:0] carries bits 7..0. Each lane starts driving EN_DLY cycles after its enable goes low, and returns to high impedance EN_DLY cycles after the enable goes high.
- R8: A step from 0xFFFF up to 0x0000, or from 0x0000 down to 0xFFFF, starts a ripple pulse that lasts RIPPLE_W cycles. No other step produces a ripple pulse.
- R9: fault_ok is low in the cycle after sig_loss is high, or after the queued-step backlog reaches LAG_LIM in magnitude. It is high otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| step_up | input | 1 | Single-cycle count-up request from the tracking loop |
| step_dn | input | 1 | Single-cycle count-down request from the tracking loop |
| inhibit_n | input | 1 | Low freezes the output latch; high lets it follow the counter |
| en_hi_n | input | 1 | Active-low enable for the upper byte lane |
| en_lo_n | input | 1 | Active-low enable for the lower byte lane |
| sig_loss | input | 1 | High when the front end has lost its input signal |
| busy | output | 1 | High while a counter step is in progress; the latch is then invalid |
| angle_bus | output | 16 | Latched angle on two byte lanes, each lane tri-stated by its own enable |
| ripple | output | 1 | Timed pulse on a full-scale wrap |
| fault_ok | output | 1 | High while tracking is healthy |

## Verification
Two functions can collide in a single cycle: the catch-up load requested by an inhibit release, and a newly queued step that wants its own busy and load sequence. The bench provokes this by raising inhibit_n in the same cycle as a step pulse. It passes if exactly one busy pulse appears and the latch then holds the stepped counter value. A second collision is an up pulse and a down pulse in the same cycle. For that case the bench expects no busy pulse and an unchanged latch.

// File: rtl/angle_if_pkg.sv
package angle_if_pkg;
  typedef enum logic [1:0] {
    SQ_IDLE = 2'd0,
    SQ_BUSY = 2'd1,
    SQ_LOAD = 2'd2
  } seq_state_e;
endpackage

// File: rtl/step_backlog.sv
// Signed backlog of step requests not yet processed by the sequencer.
module step_backlog #(
  parameter int QW      = 8,
  parameter int LAG_LIM = 32
) (
  input  logic clk,
  input  logic rst_n,
  input  logic up_i,
  input  logic dn_i,
  input  logic take_i,
  output logic pending_o,
  output logic up_dir_o,
  output logic lag_o
);
  localparam logic signed [QW-1:0] ONE   = QW'(1);
  localparam logic        [QW-1:0] LAG_V = QW'(LAG_LIM);
  localparam logic signed [QW-1:0] TOP_V = {1'b0, {(QW-1){1'b1}}};
  localparam logic signed [QW-1:0] BOT_V = {1'b1, {(QW-1){1'b0}}};

  logic signed [QW-1:0] pend_q;
  logic signed [QW-1:0] delta;
  logic        [QW-1:0] mag;

  always_comb begin
    delta = '0;
    if (up_i) delta = delta + ONE;
    if (dn_i) delta = delta - ONE;
    if (take_i) delta = (pend_q > 0) ? (delta - ONE) : (delta + ONE);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= '0;
    else        pend_q <= pend_q + delta;
  end

  assign mag       = pend_q[QW-1] ? QW'(-pend_q) : QW'(pend_q);
  assign pending_o = (pend_q != '0);
  assign up_dir_o  = (pend_q > 0);
  assign lag_o     = (mag >= LAG_V);

  // R6: backlog never reaches the edge of its range, so no request is lost
  a_r6_backlog_room: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q != TOP_V) && (pend_q != BOT_V));
endmodule

// File: rtl/angle_step_seq.sv
// Busy / load sequencer, reversible angle counter and output latch.
module angle_step_seq
  import angle_if_pkg::*;
#(
  parameter int ANGLE_W = 16,
  parameter int BUSY_W  = 20
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               take_i,
  input  logic               up_dir_i,
  input  logic               inhibit_n_i,
  output logic               consume_o,
  output logic               busy_o,
  output logic               wrap_o,
  output logic [ANGLE_W-1:0] latch_o
);
  localparam int            TW       = $clog2(BUSY_W + 1);
  localparam logic [TW-1:0] T_RELOAD = TW'(BUSY_W - 1);

  seq_state_e         st_q;
  logic [TW-1:0]      tmr_q;
  logic [ANGLE_W-1:0] ang_q;
  logic [ANGLE_W-1:0] latch_q;
  logic               inh_q;
  logic               catch_q;
  logic               inh_rise;
  logic               tmr_done;
  logic               load_end;

  assign inh_rise  = inhibit_n_i & ~inh_q;
  assign tmr_done  = (tmr_q == '0);
  assign load_end  = (st_q == SQ_LOAD) && tmr_done;
  assign consume_o = (st_q == SQ_IDLE) && take_i;
  assign wrap_o    = consume_o && (up_dir_i ? (&ang_q) : ~(|ang_q));
  assign busy_o    = (st_q == SQ_BUSY);
  assign latch_o   = latch_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= SQ_IDLE;
      tmr_q   <= '0;
      ang_q   <= '0;
      latch_q <= '0;
    end else begin
      unique case (st_q)
        SQ_IDLE: begin
          if (take_i) begin
            st_q  <= SQ_BUSY;
            tmr_q <= T_RELOAD;
            ang_q <= up_dir_i ? (ang_q + 1'b1) : (ang_q - 1'b1);
          end else if (catch_q && inhibit_n_i) begin
            st_q  <= SQ_LOAD;
            tmr_q <= T_RELOAD;
          end
        end
        SQ_BUSY: begin
          if (tmr_done) begin
            st_q  <= SQ_LOAD;
            tmr_q <= T_RELOAD;
          end else begin
            tmr_q <= tmr_q - 1'b1;
          end
        end
        SQ_LOAD: begin
          if (tmr_done) begin
            st_q <= SQ_IDLE;
            if (inhibit_n_i) latch_q <= ang_q;
          end else begin
            tmr_q <= tmr_q - 1'b1;
          end
        end
        default: st_q <= SQ_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      inh_q   <= 1'b1;
      catch_q <= 1'b0;
    end else begin
      inh_q <= inhibit_n_i;
      if (!inhibit_n_i)  catch_q <= 1'b0;
      else if (inh_rise) catch_q <= 1'b1;
      else if (load_end) catch_q <= 1'b0;
    end
  end

  // R2: taking a step always moves the counter
  a_r2_step_moves: assert property (@(posedge clk) disable iff (!rst_n)
    consume_o |=> (ang_q != $past(ang_q)));
  // R3: no latch update while busy
  a_r3_hold_in_busy: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |=> $stable(latch_q));
  // R4: inhibit freezes the latch
  a_r4_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    !inhibit_n_i |=> $stable(latch_q));
  // R5: a catch-up load is not preceded by busy
  a_r5_catchup_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == SQ_IDLE && !take_i) |=> !busy_o);
endmodule

// File: rtl/wrap_timer.sv
// Stretches a one-cycle wrap event into a timed ripple pulse.
module wrap_timer #(
  parameter int RIPPLE_W = 10000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic wrap_i,
  output logic ripple_o
);
  localparam int             RTW    = $clog2(RIPPLE_W + 1);
  localparam logic [RTW-1:0] R_LOAD = RTW'(RIPPLE_W);

  logic [RTW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt_q <= '0;
    else if (wrap_i)         cnt_q <= R_LOAD;
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign ripple_o = (cnt_q != '0);

  // R8: a wrap always starts the ripple pulse
  a_r8_ripple_start: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_i |=> ripple_o);
endmodule

// File: rtl/lane_gate.sv
// Delays one byte-lane enable by DLY cycles; output high means drive.
module lane_gate #(
  parameter int DLY = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en_n_i,
  output logic drive_o
);
  logic [DLY-1:0] pipe_q;

  for (genvar s = 0; s < DLY; s++) begin : g_stg
    if (s == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe_q[s] <= 1'b1;
        else        pipe_q[s] <= en_n_i;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe_q[s] <= 1'b1;
        else        pipe_q[s] <= pipe_q[s-1];
      end
    end
  end

  assign drive_o = ~pipe_q[DLY-1];
endmodule

// File: rtl/angle_out_if.sv
module angle_out_if #(
  parameter int ANGLE_W  = 16,
  parameter int LANE_W   = 8,
  parameter int BUSY_W   = 20,
  parameter int RIPPLE_W = 10000,
  parameter int EN_DLY   = 2,
  parameter int QW       = 8,
  parameter int LAG_LIM  = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               step_up,
  input  logic               step_dn,
  input  logic               inhibit_n,
  input  logic               en_hi_n,
  input  logic               en_lo_n,
  input  logic               sig_loss,
  output logic               busy,
  output wire  [ANGLE_W-1:0] angle_bus,
  output logic               ripple,
  output logic               fault_ok
);
  localparam int LANES = ANGLE_W / LANE_W;

  logic               pending;
  logic               up_dir;
  logic               lag;
  logic               consume;
  logic               wrap;
  logic [ANGLE_W-1:0] latch;
  logic [LANES-1:0]   en_n_v;
  logic [LANES-1:0]   drive;

  assign en_n_v = {en_hi_n, en_lo_n};

  step_backlog #(.QW(QW), .LAG_LIM(LAG_LIM)) u_backlog (
    .clk(clk), .rst_n(rst_n), .up_i(step_up), .dn_i(step_dn),
    .take_i(consume), .pending_o(pending), .up_dir_o(up_dir), .lag_o(lag)
  );

  angle_step_seq #(.ANGLE_W(ANGLE_W), .BUSY_W(BUSY_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .take_i(pending), .up_dir_i(up_dir),
    .inhibit_n_i(inhibit_n), .consume_o(consume), .busy_o(busy),
    .wrap_o(wrap), .latch_o(latch)
  );

  wrap_timer #(.RIPPLE_W(RIPPLE_W)) u_wrap (
    .clk(clk), .rst_n(rst_n), .wrap_i(wrap), .ripple_o(ripple)
  );

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    lane_gate #(.DLY(EN_DLY)) u_gate (
      .clk(clk), .rst_n(rst_n), .en_n_i(en_n_v[g]), .drive_o(drive[g])
    );
    assign angle_bus[g*LANE_W +: LANE_W] =
      drive[g] ? latch[g*LANE_W +: LANE_W] : {LANE_W{1'bz}};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) fault_ok <= 1'b1;
    else        fault_ok <= ~(sig_loss | lag);
  end

  // R9: loss of signal pulls the flag low on the next cycle
  a_r9_loss_drops: assert property (@(posedge clk) disable iff (!rst_n)
    sig_loss |=> !fault_ok);
endmodule

// File: tb/angle_out_if_tb_top.sv
`timescale 1ns/1ps
module angle_out_if_tb_top;
  localparam int BW = 4;
  localparam int RW = 40;
  localparam int ED = 2;
  localparam int LL = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic step_up = 1'b0, step_dn = 1'b0, inhibit_n = 1'b1;
  logic en_hi_n = 1'b1, en_lo_n = 1'b1, sig_loss = 1'b0;
  logic busy, ripple, fault_ok;
  tri1 [15:0] bus_w;

  int vectors = 0;
  int miscompares = 0;
  bit done = 0;
  logic [15:0] exp_cnt = 16'h0000;
  logic [15:0] shown = 16'h0000;

  int busy_rises = 0;
  int rip_rises = 0;
  int rip_len_last = 0;
  int rip_run = 0;
  bit busy_prev = 0;
  bit fault_low_seen = 0;

  always #10 clk = ~clk;

  angle_out_if #(.BUSY_W(BW), .RIPPLE_W(RW), .EN_DLY(ED), .LAG_LIM(LL)) dut_i (
    .clk(clk), .rst_n(rst_n), .step_up(step_up), .step_dn(step_dn),
    .inhibit_n(inhibit_n), .en_hi_n(en_hi_n), .en_lo_n(en_lo_n),
    .sig_loss(sig_loss), .busy(busy), .angle_bus(bus_w),
    .ripple(ripple), .fault_ok(fault_ok)
  );

  always @(negedge clk) begin
    if (busy && !busy_prev) busy_rises++;
    busy_prev = busy;
    if (ripple) rip_run++;
    else if (rip_run != 0) begin
      rip_len_last = rip_run;
      rip_rises++;
      rip_run = 0;
    end
    if (!fault_ok) fault_low_seen = 1;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  endtask

  task automatic pulse(input bit up, input bit dn);
    @(negedge clk); step_up = up; step_dn = dn;
    @(negedge clk); step_up = 0; step_dn = 0;
  endtask

  task automatic settle(input int steps);
    repeat (steps * (2*BW + 1) + 6) @(negedge clk);
  endtask

  task automatic t_reset();
    chk("R1 busy", busy, 0);
    chk("R1 ripple", ripple, 0);
    chk("R1 fault_ok", fault_ok, 1);
    chk("R1 lanes released", bus_w, 16'hFFFF);
    @(negedge clk); en_hi_n = 0; en_lo_n = 0;
    repeat (ED) @(negedge clk);
    chk("R1 latch zero", bus_w, 16'h0000);
  endtask

  task automatic t_single_step();
    int w = 0;
    int base = rip_rises;
    pulse(1, 0);
    exp_cnt = exp_cnt + 1;
    while (busy !== 1'b1) @(negedge clk);
    while (busy === 1'b1) begin
      chk("R3 latch held during busy", bus_w, 16'h0000);
      w++;
      @(negedge clk);
    end
    chk("R2 busy width", w, BW);
    repeat (BW - 1) @(negedge clk);
    chk("R3 latch before load end", bus_w, 16'h0000);
    @(negedge clk);
    chk("R3 latch after load end", bus_w, exp_cnt);
    settle(1);
    chk("R8 no ripple on plain step", rip_rises - base, 0);
  endtask

  task automatic t_wrap();
    int base = rip_rises;
    pulse(0, 1); pulse(0, 1);
    exp_cnt = exp_cnt - 2;
    settle(2);
    repeat (RW + 4) @(negedge clk);
    chk("R2 down wrap value", bus_w, 16'hFFFF);
    chk("R8 ripple on down wrap", rip_rises - base, 1);
    chk("R8 ripple width", rip_len_last, RW);
    pulse(1, 0);
    exp_cnt = exp_cnt + 1;
    settle(1);
    repeat (RW + 4) @(negedge clk);
    chk("R8 ripple on up wrap", rip_rises - base, 2);
    chk("R2 up wrap value", bus_w, 16'h0000);
  endtask

  task automatic t_queue();
    int base = busy_rises;
    @(negedge clk); step_up = 1;
    repeat (3) @(negedge clk);
    step_up = 0;
    exp_cnt = exp_cnt + 3;
    settle(3);
    chk("R6 queued steps all processed", busy_rises - base, 3);
    chk("R6 queued latch value", bus_w, exp_cnt);
    base = busy_rises;
    pulse(1, 1);
    settle(1);
    chk("R6 up+down cancel no busy", busy_rises - base, 0);
    chk("R6 up+down cancel latch", bus_w, exp_cnt);
  endtask

  task automatic t_inhibit();
    int base;
    shown = exp_cnt;
    @(negedge clk); inhibit_n = 0;
    base = busy_rises;
    pulse(1, 0); pulse(1, 0);
    exp_cnt = exp_cnt + 2;
    settle(2);
    chk("R4 counter tracks while frozen", busy_rises - base, 2);
    chk("R4 latch frozen", bus_w, shown);
    base = busy_rises;
    @(negedge clk); inhibit_n = 1;
    settle(1);
    chk("R5 release has no busy", busy_rises - base, 0);
    chk("R5 catch-up latch", bus_w, exp_cnt);
  endtask

  task automatic t_collision();
    int base;
    @(negedge clk); inhibit_n = 0;
    repeat (3) @(negedge clk);
    base = busy_rises;
    inhibit_n = 1; step_up = 1;
    @(negedge clk); step_up = 0;
    exp_cnt = exp_cnt + 1;
    settle(2);
    chk("R5 release with step one busy", busy_rises - base, 1);
    chk("R5 release with step latch", bus_w, exp_cnt);
  endtask

  task automatic t_lanes();
    @(negedge clk); en_hi_n = 1; en_lo_n = 1;
    repeat (ED) @(negedge clk);
    chk("R7 both released", bus_w, 16'hFFFF);
    @(negedge clk); en_lo_n = 0;
    repeat (ED - 1) @(negedge clk);
    chk("R7 low lane not yet driven", bus_w, 16'hFFFF);
    @(negedge clk);
    chk("R7 low lane only", bus_w, {8'hFF, exp_cnt[7:0]});
    @(negedge clk); en_lo_n = 1; en_hi_n = 0;
    repeat (ED) @(negedge clk);
    chk("R7 high lane only", bus_w, {exp_cnt[15:8], 8'hFF});
    @(negedge clk); en_lo_n = 0;
    repeat (ED) @(negedge clk);
    chk("R7 both lanes", bus_w, exp_cnt);
  endtask

  task automatic t_fault();
    @(negedge clk); sig_loss = 1;
    @(negedge clk);
    chk("R9 loss drops flag", fault_ok, 0);
    sig_loss = 0;
    @(negedge clk);
    chk("R9 flag recovers", fault_ok, 1);
    fault_low_seen = 0;
    @(negedge clk); step_up = 1;
    repeat (10) @(negedge clk);
    step_up = 0;
    exp_cnt = exp_cnt + 10;
    settle(10);
    chk("R9 backlog drops flag", fault_low_seen, 1);
    chk("R9 flag high after drain", fault_ok, 1);
    chk("R6 burst latch", bus_w, exp_cnt);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_single_step();
    t_wrap();
    t_queue();
    t_inhibit();
    t_collision();
    t_lanes();
    t_fault();
    finish_run();
  end

  initial begin
    repeat (150000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end
endmodule